// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the integer register file of a small processor core. It holds sixteen 32-bit general registers and the 32-bit status word. The low eight registers, r0 to r7, exist twice. Which copy is live depends on two status bits taken together: the privilege-mode bit and the bank-select bit. In user mode bank 0 is always live. In privileged mode the live bank is the inverse of the bank-select bit. Registers r8 to r15 have a single copy.

The live registers sit in one flat array that feeds two combinational read ports and one clocked write port. The copy that is not live is kept in a two-slot side store. When a status-word write changes the effective bank, the block exchanges r0 to r7 with the side store in that same clock edge. A third port gives direct access to the side store, so an exception handler can reach the registers of the other bank.

Four single-bit setters update the M, Q, S and T flags without a full status write. They cannot change the privileged bits. Instruction decode, interrupt acceptance and privilege checks live elsewhere.

Top module: `bank_regfile`

## Requirements
- R1: While rst_n is low at a clock edge, every register and both side-store slots become 0. The status word becomes 0x7000_0000, which sets the privileged-mode bit (bit 30), the bank-select bit (bit 29) and the block bit (bit 28). cur_bank then reads 0.
- R2: rd_a_data and rd_b_data show the live register named by their index in the same cycle. A write through wr_en/wr_idx/wr_data takes effect at the clock edge and is visible from the next cycle on.
- R3: The status bits are laid out as follows: T at bit 0, S at bit 1, interrupt mask at bits 7:4, Q at bit 8, M at bit 9, block bit at 28, bank-select bit at 29 and mode bit at 30. cur_bank equals bit30 AND NOT bit29. cur_bank changes only after a status write.
- R4: A status write that changes the effective bank stores the outgoing r0 to r7 in side slot (1 − old bank) and loads r0 to r7 from side slot (old bank). Reads in the next cycle return the other bank's values.
- R5: A status write that leaves the effective bank unchanged leaves r0 to r7 unchanged. An example is toggling bit 29 while bit 30 is 0.
- R6: Registers r8 to r15 have one copy and are not altered by any bank change.
- R7: The side-store port reads slot (NOT bit29) entry alt_rd_idx combinationally. alt_wr_en writes slot (NOT bit29) entry alt_wr_idx at the clock edge. Slot k holds bank (1 − k) while that bank is not live.
- R8: flag_en bit k loads status bit T (k=0), S (k=1), Q (k=2) or M (k=3) from flag_val bit k. Setters never alter any other status bit, including bits 28 to 30. When a setter and a status write fall in the same cycle, the setter wins on its own bit.
- R9: A write to r0 to r7 in the same cycle as a bank-changing status write lands in the outgoing bank, so it is saved into the side store.
- R10: A side-store write in the same cycle as a bank change is applied before the exchange, using the slot selected by the old bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| sr_wr_en | input | 1 | Full status-word write enable |
| sr_wr_data | input | 32 | Status-word write data |
| flag_en | input | 4 | Per-flag setter enables (T, S, Q, M) |
| flag_val | input | 4 | Per-flag setter values |
| alt_rd_idx | input | 3 | Side-store read entry |
| alt_rd_data | output | 32 | Side-store read data |
| alt_wr_en | input | 1 | Side-store write enable |
| alt_wr_idx | input | 3 | Side-store write entry |
| alt_wr_data | input | 32 | Side-store write data |
| sr_out | output | 32 | Current status word |
| cur_bank | output | 1 | Effective live bank of r0 to r7 |

## Verification
A wrong exchange direction or a missed swap cannot be hidden by the status word. It shows on the read ports in the first cycle after the status write, because r0 to r7 then hold the wrong bank's values. It also shows on the side-store port, which returns the values that should have been saved. A setter that leaks into bits 28 to 30 shows at once on sr_out and cur_bank. The bench compares every output against a behavioural model on every cycle, so such faults are reported in the cycle they first become visible.

// File: rtl/bank_regfile_pkg.sv
// Shared constants for the mode-banked register file.
// Assumes a 32-bit status word with fixed bit positions.
package bank_regfile_pkg;
    localparam int SR_W      = 32;
    localparam int SR_T      = 0;
    localparam int SR_S      = 1;
    localparam int SR_IM_LO  = 4;
    localparam int SR_IM_HI  = 7;
    localparam int SR_Q      = 8;
    localparam int SR_M      = 9;
    localparam int SR_BL     = 28;
    localparam int SR_RB     = 29;
    localparam int SR_MD     = 30;
    localparam int NUM_FLAGS = 4;
    localparam logic [SR_W-1:0] SR_RESET = (SR_W'(1) << SR_MD) | (SR_W'(1) << SR_RB) | (SR_W'(1) << SR_BL);
    // Setter lane k drives this status bit: T, S, Q, M
    localparam int FLAG_POS [NUM_FLAGS] = '{SR_T, SR_S, SR_Q, SR_M};

    // Effective bank of r0..r7 from mode and bank-select bits
    function automatic logic eff_bank(input logic md, input logic rb);
        return md & ~rb;
    endfunction
endpackage

// File: rtl/brf_status.sv
// Status-word register with single-bit flag setters.
// Assumes setters only reach non-privileged bits and override a same-cycle full write.
module brf_status
    import bank_regfile_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sr_wr_en,
    input  logic [SR_W-1:0]      sr_wr_data,
    input  logic [NUM_FLAGS-1:0] flag_en,
    input  logic [NUM_FLAGS-1:0] flag_val,
    output logic [SR_W-1:0]      sr_q,
    output logic [SR_W-1:0]      sr_d
);
    // Next status word: full write first, then per-flag setters
    always_comb begin
        sr_d = sr_wr_en ? sr_wr_data : sr_q;
        for (int k = 0; k < NUM_FLAGS; k++) begin
            if (flag_en[k]) begin
                sr_d[FLAG_POS[k]] = flag_val[k];
            end
        end
    end

    // Status register with reset into privileged mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= SR_RESET;
        end else begin
            sr_q <= sr_d;
        end
    end
endmodule

// File: rtl/brf_bank_sel.sv
// Derives the live bank, the swap request and the side-store slot.
// Assumes only a full status write can move the mode or bank-select bits.
module brf_bank_sel
    import bank_regfile_pkg::*;
(
    input  logic md_q,
    input  logic rb_q,
    input  logic md_d,
    input  logic rb_d,
    output logic cur_bank,
    output logic swap,
    output logic alt_slot
);
    logic nxt_bank;

    // Combined bank selection now and after the edge
    always_comb begin
        cur_bank = eff_bank(md_q, rb_q);
        nxt_bank = eff_bank(md_d, rb_d);
        swap     = cur_bank != nxt_bank;
        alt_slot = ~rb_q;
    end
endmodule

// File: rtl/brf_gpr_array.sv
// Live register array plus a two-slot side store for banked registers.
// Assumes swap, cur_bank and alt_slot come from the current status word.
// Slot k holds bank (1-k) while that bank is not live.
module brf_gpr_array #(
    parameter int DATA_W     = 32,
    parameter int NUM_REGS   = 16,
    parameter int NUM_BANKED = 8,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int BIDX_W    = $clog2(NUM_BANKED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alt_wr_en,
    input  logic [BIDX_W-1:0] alt_wr_idx,
    input  logic [DATA_W-1:0] alt_wr_data,
    input  logic              alt_slot,
    input  logic              swap,
    input  logic              cur_bank,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic [BIDX_W-1:0] alt_rd_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    output logic [DATA_W-1:0] alt_rd_data
);
    logic [DATA_W-1:0] act_q  [NUM_REGS];
    logic [DATA_W-1:0] act_d  [NUM_REGS];
    logic [DATA_W-1:0] slot_q [2][NUM_BANKED];
    logic [DATA_W-1:0] slot_d [2][NUM_BANKED];

    // Next state: writes land first, then the bank exchange
    always_comb begin
        act_d  = act_q;
        slot_d = slot_q;
        if (wr_en) begin
            act_d[wr_idx] = wr_data;
        end
        if (alt_wr_en) begin
            slot_d[alt_slot][alt_wr_idx] = alt_wr_data;
        end
        if (swap) begin
            for (int i = 0; i < NUM_BANKED; i++) begin
                slot_d[!cur_bank][i] = act_d[i];
                act_d[i]             = slot_d[cur_bank][i];
            end
        end
    end

    // Storage update with clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                act_q[i] <= '0;
            end
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < NUM_BANKED; i++) begin
                    slot_q[s][i] <= '0;
                end
            end
        end else begin
            act_q  <= act_d;
            slot_q <= slot_d;
        end
    end

    // Combinational read ports
    always_comb begin
        rd_a_data   = act_q[rd_a_idx];
        rd_b_data   = act_q[rd_b_idx];
        alt_rd_data = slot_q[alt_slot][alt_rd_idx];
    end
endmodule

// File: rtl/bank_regfile.sv
// Top of the mode-banked register file.
// Assumes the surrounding core sequences accesses and checks privilege itself.
module bank_regfile
    import bank_regfile_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_REGS   = 16,
    parameter int NUM_BANKED = 8,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int BIDX_W    = $clog2(NUM_BANKED)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_a_idx,
    output logic [DATA_W-1:0]    rd_a_data,
    input  logic [IDX_W-1:0]     rd_b_idx,
    output logic [DATA_W-1:0]    rd_b_data,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 sr_wr_en,
    input  logic [SR_W-1:0]      sr_wr_data,
    input  logic [NUM_FLAGS-1:0] flag_en,
    input  logic [NUM_FLAGS-1:0] flag_val,
    input  logic [BIDX_W-1:0]    alt_rd_idx,
    output logic [DATA_W-1:0]    alt_rd_data,
    input  logic                 alt_wr_en,
    input  logic [BIDX_W-1:0]    alt_wr_idx,
    input  logic [DATA_W-1:0]    alt_wr_data,
    output logic [SR_W-1:0]      sr_out,
    output logic                 cur_bank
);
    logic [SR_W-1:0] sr_d;
    logic            swap;
    logic            alt_slot;

    brf_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_wr_en   (sr_wr_en),
        .sr_wr_data (sr_wr_data),
        .flag_en    (flag_en),
        .flag_val   (flag_val),
        .sr_q       (sr_out),
        .sr_d       (sr_d)
    );

    brf_bank_sel u_bank_sel (
        .md_q     (sr_out[SR_MD]),
        .rb_q     (sr_out[SR_RB]),
        .md_d     (sr_d[SR_MD]),
        .rb_d     (sr_d[SR_RB]),
        .cur_bank (cur_bank),
        .swap     (swap),
        .alt_slot (alt_slot)
    );

    brf_gpr_array #(
        .DATA_W     (DATA_W),
        .NUM_REGS   (NUM_REGS),
        .NUM_BANKED (NUM_BANKED)
    ) u_gpr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .alt_wr_en   (alt_wr_en),
        .alt_wr_idx  (alt_wr_idx),
        .alt_wr_data (alt_wr_data),
        .alt_slot    (alt_slot),
        .swap        (swap),
        .cur_bank    (cur_bank),
        .rd_a_idx    (rd_a_idx),
        .rd_b_idx    (rd_b_idx),
        .alt_rd_idx  (alt_rd_idx),
        .rd_a_data   (rd_a_data),
        .rd_b_data   (rd_b_data),
        .alt_rd_data (alt_rd_data)
    );
endmodule

// File: rtl/brf_checker.sv
// Port-level properties of the mode-banked register file, bound to the top.
// Assumes the default 16-register, 32-bit configuration of the index ports.
module brf_checker
    import bank_regfile_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            sr_wr_en,
    input logic [3:0]      flag_en,
    input logic [3:0]      rd_a_idx,
    input logic [31:0]     rd_a_data,
    input logic [SR_W-1:0] sr_out,
    input logic            cur_bank
);
    AST_RESET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sr_out == SR_RESET && cur_bank == 1'b0)); // R1

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !sr_wr_en) |=> (!$stable(rd_a_idx) || $stable(rd_a_data))); // R2

    AST_BANK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_en |=> $stable(cur_bank)); // R3

    AST_UPPER_UNBANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rd_a_idx[3]) |=> (!$stable(rd_a_idx) || $stable(rd_a_data))); // R6

    AST_SETTER_NO_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_wr_en && flag_en != 4'b0) |=> ($stable(sr_out[31:10]) && $stable(sr_out[7:2]))); // R8
endmodule

bind bank_regfile brf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .sr_wr_en  (sr_wr_en),
    .flag_en   (flag_en),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .sr_out    (sr_out),
    .cur_bank  (cur_bank)
);

// File: tb/bank_regfile_test.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural model stepped once per clock and compared every cycle.
module bank_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data, sr_wr_data, alt_wr_data, alt_rd_data, sr_out;
    logic        wr_en, sr_wr_en, alt_wr_en, cur_bank;
    logic [3:0]  flag_en, flag_val;
    logic [2:0]  alt_rd_idx, alt_wr_idx;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    logic [31:0] m_act [16];
    logic [31:0] m_slot [2][8];
    logic [31:0] m_sr;
    logic [31:0] n_act [16];
    logic [31:0] n_slot [2][8];

    always #2.5 clk = ~clk;

    bank_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .flag_en(flag_en), .flag_val(flag_val),
        .alt_rd_idx(alt_rd_idx), .alt_rd_data(alt_rd_data),
        .alt_wr_en(alt_wr_en), .alt_wr_idx(alt_wr_idx), .alt_wr_data(alt_wr_data),
        .sr_out(sr_out), .cur_bank(cur_bank)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Model of one clock edge, written from the requirements
    task automatic model_step();
        int old_b, new_b;
        logic [31:0] nsr;
        if (!rst_n) begin
            m_sr = 32'h7000_0000;
            for (int i = 0; i < 16; i++) m_act[i] = 0;
            for (int s = 0; s < 2; s++) for (int i = 0; i < 8; i++) m_slot[s][i] = 0;
            return;
        end
        n_act = m_act;
        n_slot = m_slot;
        if (wr_en) n_act[wr_idx] = wr_data;
        if (alt_wr_en) n_slot[m_sr[29] ? 0 : 1][alt_wr_idx] = alt_wr_data;
        nsr = sr_wr_en ? sr_wr_data : m_sr;
        if (flag_en[0]) nsr[0] = flag_val[0];
        if (flag_en[1]) nsr[1] = flag_val[1];
        if (flag_en[2]) nsr[8] = flag_val[2];
        if (flag_en[3]) nsr[9] = flag_val[3];
        old_b = (m_sr[30] && !m_sr[29]) ? 1 : 0;
        new_b = (nsr[30] && !nsr[29]) ? 1 : 0;
        if (old_b != new_b) begin
            for (int i = 0; i < 8; i++) begin
                n_slot[1 - old_b][i] = n_act[i];
                n_act[i] = n_slot[old_b][i];
            end
        end
        m_act = n_act;
        m_slot = n_slot;
        m_sr = nsr;
    endtask

    task automatic idle();
        wr_en = 0; sr_wr_en = 0; alt_wr_en = 0; flag_en = 0; flag_val = 0;
        wr_idx = 0; wr_data = 0; sr_wr_data = 0; alt_wr_idx = 0; alt_wr_data = 0;
    endtask

    // Apply inputs for one edge, step the model, then compare all outputs
    task automatic tick();
        model_step();
        @(negedge clk);
        check("rd_a", rd_a_data, m_act[rd_a_idx]);
        check("rd_b", rd_b_data, m_act[rd_b_idx]);
        check("alt_rd", alt_rd_data, m_slot[m_sr[29] ? 0 : 1][alt_rd_idx]);
        check("sr", sr_out, m_sr);
        check("bank", {31'b0, cur_bank}, {31'b0, m_sr[30] & ~m_sr[29]});
        idle();
    endtask

    task automatic read_all();
        for (int i = 0; i < 16; i += 2) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(i + 1); alt_rd_idx = 3'(i / 2);
            tick();
        end
    endtask

    task automatic sr_write(input logic [31:0] v);
        sr_wr_en = 1; sr_wr_data = v;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rd_a_idx = 0; rd_b_idx = 0; alt_rd_idx = 0;
        rst_n = 0;
        @(negedge clk);
        tag = "R1";
        tick(); tick();
        check("reset sr", sr_out, 32'h7000_0000);
        rst_n = 1;
        read_all();

        tag = "R2";
        for (int i = 0; i < 16; i++) begin
            wr_en = 1; wr_idx = 4'(i); wr_data = 32'hA000_0000 + i;
            rd_a_idx = 4'(i); rd_b_idx = 4'(i);
            tick();
        end
        read_all();

        tag = "R7";
        for (int i = 0; i < 8; i++) begin
            alt_wr_en = 1; alt_wr_idx = 3'(i); alt_wr_data = 32'hB100_0000 + i;
            alt_rd_idx = 3'(i);
            tick();
        end
        read_all();

        tag = "R4";
        sr_write(32'h4000_0000);
        tick();
        check("bank after swap", {31'b0, cur_bank}, 32'd1);
        read_all();

        tag = "R6";
        rd_a_idx = 4'd12;
        sr_write(32'h6000_0000);
        tick();
        check("r12 across swap", rd_a_data, 32'hA000_000C);

        tag = "R9";
        wr_en = 1; wr_idx = 4'd3; wr_data = 32'hC0DE_0003;
        sr_write(32'h4000_0000);
        tick();
        read_all();
        sr_write(32'h6000_0000);
        rd_a_idx = 4'd3;
        tick();
        check("r3 written in outgoing bank", rd_a_data, 32'hC0DE_0003);

        tag = "R5";
        sr_write(32'h0000_0000);
        tick();
        sr_write(32'h2000_0000);
        tick();
        read_all();

        tag = "R8";
        flag_en = 4'b1111; flag_val = 4'b1111;
        tick();
        check("flags set", sr_out, 32'h2000_0303);
        flag_en = 4'b0101; flag_val = 4'b0000;
        sr_write(32'h7000_00F3);
        tick();
        flag_en = 4'b1010; flag_val = 4'b1010;
        tick();
        read_all();

        tag = "R10";
        alt_wr_en = 1; alt_wr_idx = 3'd5; alt_wr_data = 32'hD00D_0005;
        sr_write(32'h4000_0000);
        tick();
        read_all();

        tag = "RND R2 R4 R5 R7 R8 R9 R10";
        for (int c = 0; c < 600; c++) begin
            rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom); alt_rd_idx = 3'($urandom);
            wr_en = 1'($urandom); wr_idx = 4'($urandom); wr_data = $urandom;
            alt_wr_en = ($urandom % 3) == 0; alt_wr_idx = 3'($urandom); alt_wr_data = $urandom;
            sr_wr_en = ($urandom % 4) == 0;
            sr_wr_data = {1'b0, 3'($urandom), 28'($urandom)};
            flag_en = 4'($urandom); flag_val = 4'($urandom);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule